// File: doc/BRIEF.md
# Serial EEPROM core with write-protect cancellation

A 256-byte serial EEPROM slave on a two-wire bus (SCL clock, SDA data with an open-drain enable). A host writes one byte or a page of up to 8 bytes with a frame made of START, device address, word address, data bytes and STOP. The core buffers the page. It then runs an internal write cycle that a clock-cycle counter times, and commits the page to the array when the count ends. Reads return bytes in sequence, and the address rolls over from 255 to 0. While a write cycle runs, the core does not acknowledge its own device address, so a host can poll for completion.

The write-protect input (`wp_i`) can cancel a write, but only inside a defined window. From START up to the SCL rising edge that samples the last bit of the first data byte, its level has no effect. From that edge until the internal write cycle ends, a high level cancels the write. A high level before the cycle starts discards the whole page. A high level during the cycle stops the write at once: the page's addressed bytes receive a scramble pattern, and the core is idle on the next clock. The core also flags a write-protect level that changed too close before the sampling edge.

Both bus lines are sampled by the system clock and decoded from their edges. The write time and the write-protect setup window are parameters given in clock cycles.

Top module: `eewp_core`

## Requirements
- R1: After reset `sda_oe_o`, `busy_o` and `wp_err_o` are 0, and every array byte reads 8'hFF.
- R2: The core acknowledges a device address byte whose upper 7 bits equal 4'b1010 followed by `pin_sel_i` (bit 0 = 1 for read). It does not acknowledge other addresses and ignores the rest of such a frame. `sda_oe_o` changes only while SCL is low.
- R3: A STOP that follows a whole number of data bytes (at least one) starts a write cycle, and `busy_o` goes high. When the cycle ends, each byte is stored at the word address with the low 3 bits incremented and wrapping inside the 8-byte page. A later byte overwrites an earlier one on the same location.
- R4: `busy_o` stays high for exactly TWR_CYC clock cycles unless cancelled. While it is high, the device address is not acknowledged and `sda_oe_o` stays 0.
- R5: A read frame (word address, repeated START, read address) returns sequential bytes for as long as the host acknowledges. The address increments and wraps from 8'hFF to 8'h00.
- R6: The `wp_i` level from START up to the SCL rising edge that samples bit 0 of the first data byte has no effect on the write.
- R7: `wp_i` high in any cycle from that edge up to the start of the write cycle cancels the command: no byte is written and `busy_o` does not rise.
- R8: `wp_i` high during the write cycle drops `busy_o` on the next clock. The page locations addressed by the frame get SCRAMBLE (8'h5A), and the other bytes of the page keep their values. The device address is acknowledged again at once.
- R9: `wp_err_o` sets when `wp_i` last changed fewer than WP_SETUP_CYC cycles before the edge that samples bit 0 of the first data byte. It clears on the next START.
- R10: A STOP that arrives part-way through a data byte discards the command, and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| pin_sel_i | input | 3 | Device select bits compared with the address byte |
| wp_i | input | 1 | Write protect, high cancels inside the window |
| busy_o | output | 1 | Internal write cycle in progress |
| wp_err_o | output | 1 | Write-protect setup violation seen in this frame |

## Verification
Page writes are driven with random start addresses and random lengths from 1 to 10 bytes, so both in-page writes and lengths that wrap and overwrite inside the page are covered. A read-back model predicts every byte. Directed frames move the rising edge of `wp_i` around the window. A high level that falls before the first data byte's last bit must still write. A high pulse just after that bit, or at STOP, must write nothing. A high level during the write cycle must leave the scramble pattern in the addressed lanes only, and polling must show the core is ready at once. A `wp_i` change a few cycles before the sampling edge separates the setup flag from the cancellation. A STOP inside a byte, a foreign device address and a read across 8'hFF each isolate one decode path.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_DEV, BUS_WADDR, BUS_WDATA, BUS_RD, BUS_SKIP
  } bus_st_e;

  typedef enum logic {WR_IDLE, WR_CYCLE} wr_st_e;

  typedef struct packed {
    logic start;   // START or repeated START seen
    logic stop;    // STOP seen
    logic whole;   // stop lands on a data byte boundary with data received
    logic byte_v;  // data byte complete (edge sampling bit 0)
    logic first;   // that byte is the first data byte of the frame
  } bus_evt_t;
endpackage

// File: rtl/eewp_bus.sv
module eewp_bus
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        pin_sel_i,
  input  logic              busy_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output bus_evt_t          evt_o,
  output logic [7:0]        wdata_o
);
  logic scl_q, sda_q, scl_d, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;
  bus_st_e st;
  logic [3:0] cnt;
  logic ack_ph, drive, ack_ok, rnw, mack, got_data;
  logic [6:0] sh;
  logic [7:0] tx, rx_byte;
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1; sda_q <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_q <= scl_i; sda_q <= sda_i; scl_d <= scl_q; sda_d <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
  assign rx_byte   = {sh, sda_q};

  always_comb begin
    evt_o.start  = start_det;
    evt_o.stop   = stop_det;
    // the stop's own SCL rise shifts one bit, so a boundary shows as cnt==1
    evt_o.whole  = (st == BUS_WDATA) && (cnt == 4'd1) && !ack_ph && got_data;
    evt_o.byte_v = (st == BUS_WDATA) && scl_rise && !ack_ph && (cnt == 4'd7);
    evt_o.first  = !got_data;
  end

  assign wdata_o  = rx_byte;
  assign ptr_o    = ptr;
  assign sda_oe_o = drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= BUS_IDLE; cnt <= '0; ack_ph <= 1'b0; drive <= 1'b0;
      ack_ok <= 1'b0; rnw <= 1'b0; mack <= 1'b1; got_data <= 1'b0;
      sh <= '0; tx <= '0; ptr <= '0;
    end else if (start_det) begin
      st <= BUS_DEV; cnt <= '0; ack_ph <= 1'b0; drive <= 1'b0; got_data <= 1'b0;
    end else if (stop_det) begin
      st <= BUS_IDLE; cnt <= '0; ack_ph <= 1'b0; drive <= 1'b0;
    end else begin
      unique case (st)
        BUS_DEV, BUS_WADDR, BUS_WDATA: begin
          if (scl_rise && !ack_ph && cnt < 4'd8) begin
            sh  <= rx_byte[6:0];
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              ack_ok <= 1'b1;
              if (st == BUS_DEV) begin
                ack_ok <= (rx_byte[7:1] == {DEV_TYPE, pin_sel_i}) && !busy_i;
                rnw    <= rx_byte[0];
              end else if (st == BUS_WADDR) begin
                ptr <= rx_byte[ADDR_W-1:0];
              end else begin
                got_data <= 1'b1;
                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
              end
            end
          end else if (scl_fall && !ack_ph && cnt == 4'd8) begin
            ack_ph <= 1'b1;
            drive  <= ack_ok;
            cnt    <= '0;
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            drive  <= 1'b0;
            if (st == BUS_DEV) begin
              if (!ack_ok) st <= BUS_SKIP;
              else if (rnw) begin
                st    <= BUS_RD;
                drive <= ~rd_data_i[7];
                tx    <= {rd_data_i[6:0], 1'b0};
                cnt   <= 4'd1;
              end else st <= BUS_WADDR;
            end else if (st == BUS_WADDR) begin
              st <= BUS_WDATA;
            end
          end
        end
        BUS_RD: begin
          if (scl_fall && !ack_ph) begin
            if (cnt == 4'd8) begin
              drive  <= 1'b0;
              ack_ph <= 1'b1;
              ptr    <= ptr + 1'b1;
            end else begin
              drive <= ~tx[7];
              tx    <= {tx[6:0], 1'b0};
              cnt   <= cnt + 4'd1;
            end
          end else if (scl_rise && ack_ph) begin
            mack <= sda_q;
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            if (!mack) begin
              drive <= ~rd_data_i[7];
              tx    <= {rd_data_i[6:0], 1'b0};
              cnt   <= 4'd1;
            end else begin
              st <= BUS_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eewp_wr_ctrl.sv
module eewp_wr_ctrl
  import eewp_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          PAGE_W       = 3,
  parameter int          TWR_CYC      = 500000,
  parameter int          WP_SETUP_CYC = 10,
  parameter logic [7:0]  SCRAMBLE     = 8'h5A,
  localparam int         LANES        = 1 << PAGE_W,
  localparam int         ROW_W        = ADDR_W - PAGE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  bus_evt_t             evt_i,
  input  logic [7:0]           wdata_i,
  input  logic [ADDR_W-1:0]    ptr_i,
  input  logic                 wp_i,
  output logic                 busy_o,
  output logic                 wp_err_o,
  output logic                 mem_we_o,
  output logic [ROW_W-1:0]     mem_row_o,
  output logic [LANES-1:0]     mem_mask_o,
  output logic [LANES*8-1:0]   mem_wdata_o
);
  localparam int TW_W = $clog2(TWR_CYC + 1);
  localparam int SU_W = $clog2(WP_SETUP_CYC + 1);

  wr_st_e st;
  logic [LANES-1:0][7:0] page_buf;
  logic [LANES-1:0] mask;
  logic [ROW_W-1:0] row;
  logic win, cancel, wp_d, err, finish, launch, win_hit, first_edge;
  logic [TW_W-1:0] timer;
  logic [SU_W-1:0] su_cnt;

  assign first_edge = evt_i.byte_v && evt_i.first;
  assign finish  = (st == WR_CYCLE) && (wp_i || timer == TW_W'(TWR_CYC - 1));
  assign launch  = evt_i.stop && evt_i.whole && (|mask) && !cancel && !wp_i;
  assign win_hit = (win || first_edge) && wp_i;

  assign busy_o      = (st == WR_CYCLE);
  assign wp_err_o    = err;
  assign mem_we_o    = finish;
  assign mem_row_o   = row;
  assign mem_mask_o  = mask;
  assign mem_wdata_o = wp_i ? {LANES{SCRAMBLE}} : page_buf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_d   <= 1'b0;
      su_cnt <= SU_W'(WP_SETUP_CYC);
    end else begin
      wp_d <= wp_i;
      if (wp_i != wp_d) su_cnt <= '0;
      else if (su_cnt < SU_W'(WP_SETUP_CYC)) su_cnt <= su_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= WR_IDLE; page_buf <= '0; mask <= '0; row <= '0;
      win <= 1'b0; cancel <= 1'b0; err <= 1'b0; timer <= '0;
    end else begin
      if (evt_i.start) err <= 1'b0;
      else if (st == WR_IDLE && first_edge && su_cnt < SU_W'(WP_SETUP_CYC)) err <= 1'b1;

      unique case (st)
        WR_IDLE: begin
          if (launch) begin
            st    <= WR_CYCLE;
            timer <= '0;
            win   <= 1'b0;
          end else if (evt_i.start || evt_i.stop) begin
            mask <= '0; win <= 1'b0; cancel <= 1'b0;
          end else begin
            if (evt_i.byte_v) begin
              page_buf[ptr_i[PAGE_W-1:0]] <= wdata_i;
              mask[ptr_i[PAGE_W-1:0]]     <= 1'b1;
              if (evt_i.first) begin
                row <= ptr_i[ADDR_W-1:PAGE_W];
                win <= 1'b1;
              end
            end
            if (win_hit) cancel <= 1'b1;
          end
        end
        WR_CYCLE: begin
          timer <= timer + 1'b1;
          if (finish) begin
            st <= WR_IDLE; mask <= '0; cancel <= 1'b0;
          end
        end
        default: st <= WR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eewp_mem.sv
module eewp_mem #(
  parameter int         ADDR_W = 8,
  parameter int         PAGE_W = 3,
  parameter logic [7:0] ERASED = 8'hFF,
  localparam int        LANES  = 1 << PAGE_W,
  localparam int        ROW_W  = ADDR_W - PAGE_W,
  localparam int        ROWS   = 1 << ROW_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ROW_W-1:0]   row_i,
  input  logic [LANES-1:0]   mask_i,
  input  logic [LANES*8-1:0] wdata_i,
  input  logic [ADDR_W-1:0]  raddr_i,
  output logic [7:0]         rdata_o
);
  logic [LANES*8-1:0] rows_q [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic [LANES*8-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= {LANES{ERASED}};
      else if (we_i && row_i == ROW_W'(g)) begin
        for (int l = 0; l < LANES; l++)
          if (mask_i[l]) q[l*8 +: 8] <= wdata_i[l*8 +: 8];
      end
    end
    assign rows_q[g] = q;
  end

  assign rdata_o = rows_q[raddr_i[ADDR_W-1:PAGE_W]][raddr_i[PAGE_W-1:0]*8 +: 8];
endmodule

// File: rtl/eewp_core.sv
module eewp_core
  import eewp_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter int         PAGE_W       = 3,
  parameter int         TWR_CYC      = 500000,
  parameter int         WP_SETUP_CYC = 10,
  parameter logic [7:0] SCRAMBLE     = 8'h5A
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] pin_sel_i,
  input  logic       wp_i,
  output logic       busy_o,
  output logic       wp_err_o
);
  localparam int LANES = 1 << PAGE_W;
  localparam int ROW_W = ADDR_W - PAGE_W;

  bus_evt_t           evt;
  logic [7:0]         wdata, rdata;
  logic [ADDR_W-1:0]  ptr;
  logic               mem_we;
  logic [ROW_W-1:0]   mem_row;
  logic [LANES-1:0]   mem_mask;
  logic [LANES*8-1:0] mem_wdata;

  eewp_bus #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_bus (
    .clk_i, .rst_ni, .scl_i, .sda_i, .pin_sel_i,
    .busy_i(busy_o), .rd_data_i(rdata), .sda_oe_o,
    .ptr_o(ptr), .evt_o(evt), .wdata_o(wdata)
  );

  eewp_wr_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC),
    .WP_SETUP_CYC(WP_SETUP_CYC), .SCRAMBLE(SCRAMBLE)
  ) u_ctrl (
    .clk_i, .rst_ni, .evt_i(evt), .wdata_i(wdata), .ptr_i(ptr), .wp_i,
    .busy_o, .wp_err_o, .mem_we_o(mem_we), .mem_row_o(mem_row),
    .mem_mask_o(mem_mask), .mem_wdata_o(mem_wdata)
  );

  eewp_mem #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
    .clk_i, .rst_ni, .we_i(mem_we), .row_i(mem_row), .mask_i(mem_mask),
    .wdata_i(mem_wdata), .raddr_i(ptr), .rdata_o(rdata)
  );
endmodule

// File: rtl/eewp_core_chk.sv
module eewp_core_chk #(
  parameter int TWR_CYC = 500000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic sda_oe_o,
  input logic busy_o
);
  localparam int BW = $clog2(TWR_CYC + 1) + 1;
  logic [BW-1:0] busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= '0;
    else if (!busy_o) busy_run <= '0;
    else if (busy_run < BW'(TWR_CYC + 1)) busy_run <= busy_run + 1'b1;
  end

  p_oe_scl_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_i));

  p_busy_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_run < BW'(TWR_CYC));

  p_busy_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  p_no_launch_wp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));

  p_abort_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && wp_i) |=> !busy_o);
endmodule

bind eewp_core eewp_core_chk #(.TWR_CYC(TWR_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .wp_i(wp_i),
  .sda_oe_o(sda_oe_o), .busy_o(busy_o)
);

// File: tb/tb_eewp_core.sv
module tb_eewp_core;
  localparam int TWR = 400;
  localparam int SETUP = 10;
  localparam int Q = 5;
  localparam logic [2:0] PSEL = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, PSEL, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, PSEL, 1'b1};
  localparam logic [7:0] SCR = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1, wp = 1'b0;
  logic sda_oe, busy, wp_err, sda_line;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model [256];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #5 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  eewp_core #(.TWR_CYC(TWR), .WP_SETUP_CYC(SETUP), .SCRAMBLE(SCR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .pin_sel_i(PSEL), .wp_i(wp), .busy_o(busy), .wp_err_o(wp_err)
  );

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i2c_start;
    sda_h = 1; tick(Q); scl = 1; tick(Q); sda_h = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic i2c_stop;
    sda_h = 0; tick(Q); scl = 1; tick(Q); sda_h = 1; tick(Q);
  endtask
  task automatic send_bit(input logic b);
    sda_h = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, input int wp_lsb, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0 && wp_lsb >= 0) wp = wp_lsb[0];
      send_bit(b[i]);
    end
    sda_h = 1; tick(Q); scl = 1; tick(Q); ack = (sda_line == 1'b0); tick(Q); scl = 0; tick(Q);
  endtask
  task automatic recv_byte(input bit last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1; tick(Q); scl = 1; tick(Q); b[i] = sda_line; tick(Q); scl = 0; tick(Q);
    end
    send_bit(last);
    sda_h = 1;
  endtask

  task automatic wr_frame(input logic [7:0] a, input int n);
    bit ack;
    i2c_start; send_byte(DEVW, -1, ack); send_byte(a, -1, ack);
    for (int k = 0; k < n; k++) send_byte(wbuf[k], -1, ack);
    i2c_stop;
  endtask

  task automatic rd_seq(input logic [7:0] a, input int n, output bit dack);
    bit ack;
    i2c_start; send_byte(DEVW, -1, dack); send_byte(a, -1, ack);
    i2c_start; send_byte(DEVR, -1, ack);
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    i2c_stop;
  endtask

  task automatic poll(output bit ack);
    i2c_start; send_byte(DEVW, -1, ack); i2c_stop;
  endtask

  task automatic wait_ready;
    bit ack = 0;
    for (int t = 0; t < 40 && !ack; t++) poll(ack);
    check(ack, "R4 ready after write", 32'(ack), 1);
  endtask

  function automatic logic [7:0] lane_addr(input logic [7:0] a, input int k);
    return {a[7:3], 3'(int'(a[2:0]) + k)};
  endfunction

  task automatic model_write(input logic [7:0] a, input int n);
    for (int k = 0; k < n; k++) model[lane_addr(a, k)] = wbuf[k];
  endtask

  task automatic verify_page(input logic [7:0] a, input string req);
    bit dack;
    logic [7:0] base;
    base = {a[7:3], 3'b000};
    rd_seq(base, 8, dack);
    for (int k = 0; k < 8; k++)
      check(rbuf[k] === model[base + 8'(k)], req, rbuf[k], model[base + 8'(k)]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ack, dack;
    logic [7:0] a;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    tick(4); rst_n = 1; tick(4);

    // R1 reset state
    check(!sda_oe && !busy && !wp_err, "R1 reset outputs", {sda_oe, busy, wp_err}, 0);
    rd_seq(8'h10, 4, dack);
    for (int k = 0; k < 4; k++) check(rbuf[k] === 8'hFF, "R1 erased read", rbuf[k], 8'hFF);

    // R2 foreign address is ignored
    i2c_start; send_byte({4'b1010, 3'b011, 1'b0}, -1, ack);
    check(!ack, "R2 foreign address nack", 32'(ack), 0);
    send_byte(8'h10, -1, ack); send_byte(8'h33, -1, ack); i2c_stop;
    check(!busy, "R2 foreign frame no write", 32'(busy), 0);
    rd_seq(8'h10, 1, dack);
    check(dack, "R2 own address ack", 32'(dack), 1);
    check(rbuf[0] === 8'hFF, "R2 foreign data ignored", rbuf[0], 8'hFF);

    // R3/R4 directed page write and busy window
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_frame(8'h26, 3); model_write(8'h26, 3);
    check(busy, "R3 busy after stop", 32'(busy), 1);
    poll(ack);
    check(!ack, "R4 poll nack while busy", 32'(ack), 0);
    tick(TWR - 260);
    check(busy, "R4 busy held", 32'(busy), 1);
    tick(80);
    check(!busy, "R4 busy released", 32'(busy), 0);
    verify_page(8'h26, "R3 page data");

    // R3 wrap inside page, overwrite
    for (int k = 0; k < 11; k++) wbuf[k] = 8'(8'hA0 + k);
    wr_frame(8'h3D, 11); model_write(8'h3D, 11);
    wait_ready; verify_page(8'h3D, "R3 wrap overwrite");

    // R5 read across 8'hFF
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2;
    wr_frame(8'hFE, 2); model_write(8'hFE, 2); wait_ready;
    wbuf[0] = 8'hD0; wr_frame(8'h00, 1); model_write(8'h00, 1); wait_ready;
    rd_seq(8'hFE, 4, dack);
    for (int k = 0; k < 4; k++)
      check(rbuf[k] === model[8'(254 + k)], "R5 sequential wrap", rbuf[k], model[8'(254 + k)]);

    // R6 wp high before the window is ignored
    wp = 1; i2c_start; send_byte(DEVW, -1, ack); send_byte(8'h50, -1, ack);
    wp = 0; tick(30);
    wbuf[0] = 8'h5C; wbuf[1] = 8'h6D;
    send_byte(wbuf[0], -1, ack); send_byte(wbuf[1], -1, ack); i2c_stop;
    model_write(8'h50, 2);
    check(busy, "R6 write starts", 32'(busy), 1);
    check(!wp_err, "R9 no setup error", 32'(wp_err), 0);
    wait_ready; verify_page(8'h50, "R6 data written");

    // R7 wp pulse just after the first byte cancels
    i2c_start; send_byte(DEVW, -1, ack); send_byte(8'h60, -1, ack);
    send_byte(8'h77, -1, ack); wp = 1; tick(3); wp = 0;
    send_byte(8'h78, -1, ack); i2c_stop;
    check(!busy, "R7 pulse cancels", 32'(busy), 0);
    verify_page(8'h60, "R7 no byte written");
    // R7 wp high at stop cancels
    i2c_start; send_byte(DEVW, -1, ack); send_byte(8'h68, -1, ack);
    send_byte(8'h99, -1, ack); wp = 1; i2c_stop; tick(2);
    check(!busy, "R7 wp at stop cancels", 32'(busy), 0);
    wp = 0; tick(20);
    verify_page(8'h68, "R7 no byte written at stop");

    // R8 wp during write cycle aborts with scramble
    wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
    wr_frame(8'h4E, 3);
    tick(100);
    check(busy, "R8 cycle running", 32'(busy), 1);
    wp = 1; tick(2);
    check(!busy, "R8 busy drops", 32'(busy), 0);
    wp = 0; tick(20);
    for (int k = 0; k < 3; k++) model[lane_addr(8'h4E, k)] = SCR;
    poll(ack);
    check(ack, "R8 ready at once", 32'(ack), 1);
    verify_page(8'h4E, "R8 scramble lanes");

    // R9 wp change just before the sampling edge
    wp = 1; tick(30);
    i2c_start; send_byte(DEVW, -1, ack); send_byte(8'h70, -1, ack);
    wbuf[0] = 8'hE7; send_byte(wbuf[0], 0, ack);
    check(wp_err, "R9 setup violation flagged", 32'(wp_err), 1);
    i2c_stop; model_write(8'h70, 1);
    check(wp_err, "R9 flag held to stop", 32'(wp_err), 1);
    check(busy, "R9 write proceeds", 32'(busy), 1);
    i2c_start;
    check(!wp_err, "R9 cleared on start", 32'(wp_err), 0);
    i2c_stop;
    wait_ready; verify_page(8'h70, "R9 data written");

    // R10 stop inside a byte discards
    i2c_start; send_byte(DEVW, -1, ack); send_byte(8'h80, -1, ack);
    send_byte(8'h12, -1, ack); send_byte(8'h34, -1, ack);
    for (int b = 0; b < 4; b++) send_bit(1'b0);
    i2c_stop;
    check(!busy, "R10 no cycle", 32'(busy), 0);
    verify_page(8'h80, "R10 array unchanged");

    // R3 random page writes
    for (int it = 0; it < 10; it++) begin
      a = 8'($urandom);
      n = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      wr_frame(a, n); model_write(a, n);
      check(busy, "R3 random busy", 32'(busy), 1);
      wait_ready; verify_page(a, "R3 random data");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule